// File: doc/BRIEF.md
# Pilot-Aided Gain Normalizer

This block sits after carrier and timing recovery in a satellite receiver. Known pilot symbols are spread through the stream. The block uses them to measure how strong the received signal is, then scales every symbol so that the constellation returns to its nominal size. Each accepted pilot is correlated with the expected pilot value, and that gives one amplitude estimate. A fixed number of these estimates is averaged into a single gain figure, which is held until the next block of pilots completes. All symbols, pilots and data alike, are divided by the held gain.

The division is done with a reciprocal. A sequential divider computes it once for each gain update, and every symbol is then multiplied by it. The stream path therefore has a fixed latency of one cycle, and no divider lies in the per-symbol path. All samples are signed fixed point with `FRAC` fractional bits, so the value 1.0 is `2^FRAC` (4096 with the defaults).

Top module: `pilot_gain_norm`

## Requirements
- R1: After reset, `out_valid`, `out_i` and `out_q` are 0 and the reciprocal is unity (`2^FRAC`), so symbols pass through unchanged until the first gain update.
- R2: A pilot is counted only in a cycle where both `in_valid` and `in_pilot` are 1. Its estimate is floor((in_i*ref_i + in_q*ref_q) / 2^FRAC), which is the real part of the symbol times the conjugate reference.
- R3: When `NAVG` (32) pilots have been counted, the block average floor(sum of estimates / NAVG) is formed. The pilot count and the sum then restart from zero.
- R4: A positive block average A sets the reciprocal to min(floor(2^(2*FRAC) / A), 2^DW - 1). The symbol accepted in the cycle right after the last pilot still uses the old reciprocal. Symbols accepted `2*FRAC+3` (27) or more cycles after the last pilot use the new one.
- R5: A block average of zero or less is discarded and the previous reciprocal stays in force.
- R6: Each accepted symbol, pilot or data, gives out_x = floor(in_x * recip / 2^FRAC) for the I and Q components separately, saturated to the signed `DW`-bit range [-32768, 32767].
- R7: `out_valid` equals `in_valid` delayed by one cycle. `out_i` and `out_q` change only in a cycle after `in_valid` was 1, and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input symbol strobe |
| in_pilot | input | 1 | Marks the current input symbol as a pilot |
| in_i | input | DW | Input in-phase component, signed |
| in_q | input | DW | Input quadrature component, signed |
| ref_i | input | DW | Expected pilot in-phase value, signed |
| ref_q | input | DW | Expected pilot quadrature value, signed |
| out_valid | output | 1 | Output symbol strobe |
| out_i | output | DW | Corrected in-phase component, signed |
| out_q | output | DW | Corrected quadrature component, signed |

## Verification
The reciprocal is never visible at the ports. Its value and the moment it changes can only be inferred from how later symbols are scaled. The stimulus therefore completes each pilot block, sends one data symbol in the very next cycle to catch the old gain, then waits past the divider window and probes with chosen symbols.

The harder states are a block whose average is negative, and a block that is one pilot short while `in_pilot` is raised without `in_valid`. Both must leave the gain untouched. The stimulus reaches them by feeding inverted pilots, and by feeding 31 valid pilots followed by strobe-less pilot flags. In each case a probe symbol follows, whose expected output differs between the old gain and any wrongly applied new one.

// File: rtl/gnorm_pkg.sv
// Package: default sizes shared by the gain normalizer modules.
// Assumes the fixed-point convention in which 1.0 equals 2**GN_FRAC.
package gnorm_pkg;
    localparam int GN_DW   = 16;  // sample width, signed
    localparam int GN_FRAC = 12;  // fractional bits of samples and gain
    localparam int GN_NAVG = 32;  // pilot estimates per block, power of two
endpackage

// File: rtl/gn_pilot_avg.sv
// Module: per-pilot amplitude estimate and block averaging.
// Forms the real part of pilot times the conjugate reference, sums NAVG
// estimates, and emits the floor-average with a one-cycle strobe when it
// is positive. Assumes NAVG is a power of two of at least 2.
module gn_pilot_avg #(
    parameter int DW   = gnorm_pkg::GN_DW,
    parameter int FRAC = gnorm_pkg::GN_FRAC,
    parameter int NAVG = gnorm_pkg::GN_NAVG,
    localparam int ACCW = 2*DW + 1 + $clog2(NAVG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_pilot,
    input  logic signed [DW-1:0]   in_i,
    input  logic signed [DW-1:0]   in_q,
    input  logic signed [DW-1:0]   ref_i,
    input  logic signed [DW-1:0]   ref_q,
    output logic signed [ACCW-1:0] avg_o,
    output logic                   upd_o
);
    localparam int LOG2N = $clog2(NAVG);
    localparam int PW    = 2*DW + 1;

    logic signed [2*DW-1:0] prod_i, prod_q;
    logic signed [PW-1:0]   corr, est;
    logic signed [ACCW-1:0] acc, acc_nx, blk_avg;
    logic [LOG2N-1:0]       pcnt;
    logic                   take, last, blk_pos;

    // Purpose: correlate the pilot with the reference and extend the running sum.
    always_comb begin
        prod_i  = in_i * ref_i;
        prod_q  = in_q * ref_q;
        corr    = PW'(prod_i) + PW'(prod_q);
        est     = corr >>> FRAC;
        acc_nx  = acc + ACCW'(est);
        blk_avg = acc_nx >>> LOG2N;
        take    = in_valid & in_pilot;
        last    = (pcnt == LOG2N'(NAVG - 1));
        blk_pos = !blk_avg[ACCW-1] && (blk_avg != '0);
    end

    // Purpose: count pilots, accumulate, and latch a positive block average.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt  <= '0;
            acc   <= '0;
            avg_o <= '0;
            upd_o <= 1'b0;
        end else begin
            upd_o <= 1'b0;
            if (take) begin
                if (last) begin
                    pcnt <= '0;
                    acc  <= '0;
                    if (blk_pos) begin
                        avg_o <= blk_avg;
                        upd_o <= 1'b1;
                    end
                end else begin
                    pcnt <= pcnt + 1'b1;
                    acc  <= acc_nx;
                end
            end
        end
    end

    // R5: a non-positive block average never produces an update strobe
    a_r5_skip_nonpos: assert property (@(posedge clk) disable iff (!rst_n)
        (take && last && !blk_pos) |=> !upd_o);
    // R3: an update only follows a completed block, so the count has restarted
    a_r3_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (pcnt == '0));
    // R3: a published average is always positive
    a_r3_avg_positive: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (!avg_o[ACCW-1] && avg_o != '0));
endmodule

// File: rtl/gn_recip_div.sv
// Module: sequential restoring divider producing 2**(2*FRAC) / divisor.
// One quotient bit per cycle; the held reciprocal is replaced only when a
// division finishes, clamped to RW bits. Assumes RW < 2*FRAC+1 and that
// start is never raised while a division is running.
module gn_recip_div #(
    parameter int DVW  = 2*gnorm_pkg::GN_DW + 1 + $clog2(gnorm_pkg::GN_NAVG),
    parameter int FRAC = gnorm_pkg::GN_FRAC,
    parameter int RW   = gnorm_pkg::GN_DW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [DVW-1:0] dvsr,
    output logic [RW-1:0]  recip,
    output logic           busy
);
    localparam int NUMW = 2*FRAC + 1;
    localparam int CW   = $clog2(NUMW);
    localparam logic [NUMW-1:0] RMAX  = NUMW'({RW{1'b1}});
    localparam logic [RW-1:0]   UNITY = RW'(1) << FRAC;

    logic [CW-1:0]   cnt;
    logic [DVW-1:0]  rem, dv;
    logic [NUMW-1:0] quo, quo_nx;
    logic [DVW:0]    rem_sh, diff;
    logic            nbit, ge;

    // Purpose: one restoring step; the numerator is a single 1 at its top bit.
    always_comb begin
        nbit   = (cnt == CW'(NUMW - 1));
        rem_sh = {rem, nbit};
        diff   = rem_sh - {1'b0, dv};
        ge     = !diff[DVW];
        quo_nx = {quo[NUMW-2:0], ge};
    end

    // Purpose: run the division and publish the clamped reciprocal at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt   <= '0;
            rem   <= '0;
            dv    <= '0;
            quo   <= '0;
            recip <= UNITY;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(NUMW - 1);
            rem  <= '0;
            dv   <= dvsr;
            quo  <= '0;
        end else if (busy) begin
            rem <= ge ? diff[DVW-1:0] : rem_sh[DVW-1:0];
            quo <= quo_nx;
            cnt <= cnt - 1'b1;
            if (cnt == '0) begin
                busy  <= 1'b0;
                recip <= (quo_nx > RMAX) ? {RW{1'b1}} : quo_nx[RW-1:0];
            end
        end
    end

    // R4: a new block never arrives while a division is in progress
    a_r4_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
    // R4: the reciprocal moves only at the end of a division
    a_r4_recip_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(recip));
    // R4: the reciprocal never collapses to zero
    a_r4_recip_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        recip != '0);
endmodule

// File: rtl/gn_apply.sv
// Module: multiplies each complex symbol by the held reciprocal.
// One lane per component, generated; each lane rescales by 2**-FRAC with
// floor and saturates to DW bits. Latency is one cycle, and the valid
// strobe is delayed to match.
module gn_apply #(
    parameter int DW   = gnorm_pkg::GN_DW,
    parameter int RW   = gnorm_pkg::GN_DW,
    parameter int FRAC = gnorm_pkg::GN_FRAC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic [RW-1:0]        recip,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);
    localparam int PWD = DW + RW + 1;
    localparam int NL  = 2;
    localparam logic signed [PWD-1:0] MAXV = {{(PWD-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PWD-1:0] MINV = {{(PWD-DW+1){1'b1}}, {(DW-1){1'b0}}};

    logic signed [DW-1:0] xin  [NL];
    logic signed [DW-1:0] yout [NL];

    assign xin[0] = in_i;
    assign xin[1] = in_q;
    assign out_i  = yout[0];
    assign out_q  = yout[1];

    for (genvar g = 0; g < NL; g++) begin : gen_lane
        logic signed [PWD-1:0] prod, sh;
        logic signed [DW-1:0]  ysat;

        // Purpose: scale the component and clip it to the output range.
        always_comb begin
            prod = xin[g] * $signed({1'b0, recip});
            sh   = prod >>> FRAC;
            if (sh > MAXV)      ysat = MAXV[DW-1:0];
            else if (sh < MINV) ysat = MINV[DW-1:0];
            else                ysat = sh[DW-1:0];
        end

        // Purpose: register the lane result on accepted symbols only.
        always_ff @(posedge clk) begin
            if (!rst_n)        yout[g] <= '0;
            else if (in_valid) yout[g] <= ysat;
        end
    end

    // Purpose: delay the strobe by the datapath latency.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // R7: valid follows the input strobe one cycle later
    a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r7_valid_low: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R7: outputs hold when no symbol was accepted
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_i) && $stable(out_q)));
endmodule

// File: rtl/pilot_gain_norm.sv
// Module: top of the pilot-aided gain normalizer.
// Averages pilot amplitude estimates, turns the held average into a
// reciprocal, and multiplies the whole stream by it. Assumes an already
// time- and frequency-aligned stream, and NAVG > 2*FRAC+2 so that a
// division always finishes before the next block completes.
module pilot_gain_norm #(
    parameter int DW   = gnorm_pkg::GN_DW,
    parameter int FRAC = gnorm_pkg::GN_FRAC,
    parameter int NAVG = gnorm_pkg::GN_NAVG
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_pilot,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic signed [DW-1:0] ref_i,
    input  logic signed [DW-1:0] ref_q,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_i,
    output logic signed [DW-1:0] out_q
);
    localparam int ACCW = 2*DW + 1 + $clog2(NAVG);
    localparam int RW   = DW;

    logic signed [ACCW-1:0] avg;
    logic                   upd;
    logic [RW-1:0]          recip;
    logic                   div_busy;

    gn_pilot_avg #(.DW(DW), .FRAC(FRAC), .NAVG(NAVG)) u_avg (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pilot(in_pilot),
        .in_i(in_i), .in_q(in_q), .ref_i(ref_i), .ref_q(ref_q),
        .avg_o(avg), .upd_o(upd)
    );

    gn_recip_div #(.DVW(ACCW), .FRAC(FRAC), .RW(RW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(upd), .dvsr(avg),
        .recip(recip), .busy(div_busy)
    );

    gn_apply #(.DW(DW), .RW(RW), .FRAC(FRAC)) u_app (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .recip(recip), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    // R1: out of reset nothing is presented
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_i == '0 && out_q == '0));
    // R4: an update strobe always launches a division on the next cycle
    a_r4_update_starts_div: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> div_busy);
endmodule

// File: tb/pilot_gain_norm_tb.sv
`timescale 1ns/1ps
module pilot_gain_norm_tb;
    localparam int DW = 16, FRAC = 12, NAVG = 32;
    localparam int SETTLE = 2*FRAC + 3 + 3;

    // Stimulus table, gain 0.5 learned: {in_i, in_q, exp_i, exp_q}
    localparam int NV = 6;
    localparam int VEC [NV][4] = '{
        '{  1000,   -500,  2000,  -1000},
        '{-16384,      0, -32768,     0},
        '{ 16384,      1, 32767,      2},
        '{ 20000, -20000, 32767, -32768},
        '{    -3,      7,    -6,     14},
        '{     0,      0,     0,      0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_pilot = 1'b0;
    logic signed [DW-1:0] in_i = '0, in_q = '0, ref_i = '0, ref_q = '0;
    logic out_valid;
    logic signed [DW-1:0] out_i, out_q;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pilot_gain_norm #(.DW(DW), .FRAC(FRAC), .NAVG(NAVG)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pilot(in_pilot),
        .in_i(in_i), .in_q(in_q), .ref_i(ref_i), .ref_q(ref_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_pilot = 1'b0;
        end
    endtask

    // One data symbol, checked one cycle later.
    task automatic sym(int xi, int xq, int ei, int eq, string tag);
        @(negedge clk);
        in_valid = 1'b1; in_pilot = 1'b0;
        in_i = DW'(xi);  in_q = DW'(xq);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, int'(out_valid), 1);
        check({tag, " I"}, int'(out_i), ei);
        check({tag, " Q"}, int'(out_q), eq);
    endtask

    task automatic pilots(int n, int xi, int xq, int ri, int rq);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_pilot = 1'b1;
            in_i = DW'(xi);  in_q = DW'(xq);
            ref_i = DW'(ri); ref_q = DW'(rq);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset I", int'(out_i), 0);
        check("R1 reset Q", int'(out_q), 0);
        rst_n = 1'b1;
        // R1: unity gain before any block
        sym(1234, -4321, 1234, -4321, "R1 unity");
        sym(-32768, 32767, -32768, 32767, "R1 unity extremes");

        // R3: alternating pilots average to 2048; the last pilot leaves at unity
        for (int k = 0; k < NAVG; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_pilot = 1'b1;
            in_i = (k % 2 == 1) ? 16'sd3072 : 16'sd1024; in_q = '0;
            ref_i = 16'sd4096; ref_q = '0;
        end
        @(negedge clk);
        check("R6 pilot corrected I", int'(out_i), 3072);
        in_pilot = 1'b0; in_i = 16'sd1000; in_q = '0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 old gain right after block", int'(out_i), 1000);
        idle(SETTLE);

        // R6: table walk at reciprocal 8192, including saturation
        for (int v = 0; v < NV; v++)
            sym(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], "R6 table");

        // R2: both components correlate, floor of estimate (4095), reciprocal 4097
        pilots(NAVG, 2896, 2896, 2896, 2896);
        idle(SETTLE);
        sym(4095, 0, 4095, 0, "R2 floor estimate");
        sym(-4096, 0, -4097, 0, "R4 reciprocal floor");

        // R5: negative average leaves the gain unchanged
        pilots(NAVG, -2048, 0, 4096, 0);
        idle(SETTLE);
        sym(-4096, 0, -4097, 0, "R5 negative average ignored");

        // R2: pilot flag without valid is not counted
        pilots(NAVG - 1, 8192, 0, 4096, 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            in_valid = 1'b0; in_pilot = 1'b1; in_i = 16'sd1;
        end
        idle(SETTLE);
        sym(-4096, 0, -4097, 0, "R2 strobe-less pilots not counted");
        pilots(1, 8192, 0, 4096, 0);
        idle(SETTLE);
        sym(1000, 0, 500, 0, "R3 block completes on 32nd valid pilot");
        sym(-1001, 0, -501, 0, "R3 gain above unity floor");

        // R4: average of 1 clamps the reciprocal to 65535
        pilots(NAVG, 1, 0, 4096, 0);
        idle(SETTLE);
        sym(100, 0, 1599, 0, "R4 clamp positive");
        sym(0, -100, 0, -1600, "R4 clamp negative");

        // R7: no strobe, outputs held
        @(negedge clk);
        check("R7 valid low", int'(out_valid), 0);
        check("R7 hold Q", int'(out_q), -1600);

        // R1: reset mid-run restores unity
        rst_n = 1'b0;
        idle(2);
        check("R1 re-reset valid", int'(out_valid), 0);
        check("R1 re-reset Q", int'(out_q), 0);
        rst_n = 1'b1;
        sym(1234, -4321, 1234, -4321, "R1 unity after re-reset");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule